// File: doc/BRIEF.md
# Sequential Duplex Result Checker

This block judges a computation that a single processor executes twice, once per software variant, one run after the other. The result of the first run is held in a register. When the second result arrives, the block gives a final verdict. Each result comes with a parity bit, the address it belongs to and a flag that says whether the instruction that produced it was valid.

Every run goes through three absolute tests: a parity test, an instruction-validity test and a test that the address lies inside a window. The window bounds can be programmed. If both runs pass their absolute tests, a relative test compares the two result words. The system result is accepted only if both words agree, which is a 2-out-of-2 decision.

One cycle after the second result, the block emits a single-cycle completion pulse. At the same time it presents a pass flag and a three-bit cause code, and it holds both until the next verdict. Any recovery action is left to the logic that consumes the verdict.

Top module: `duplex_result_checker`

## Requirements
- R1: `pass` is set with a verdict only when both runs pass every absolute test and their result words are equal. In that case `cause` is 0. Otherwise `pass` is clear and `cause` is nonzero.
- R2: Results marked by `resultValid` alternate between first run and second run. The first result is held until the second arrives. The second strobe may follow the first in the very next cycle or after any gap.
- R3: Parity test. With `ODD_PARITY`=0, a result is good when the XOR of all `resultData` bits equals `resultParity`. With `ODD_PARITY`=1, the bit must be the inverse of that XOR. A failure gives cause 1.
- R4: A result strobed while `instrValid` is low fails the instruction test, with cause 2.
- R5: The address test passes when `boundLo` <= `resultAddr` <= `boundHi`, with both ends included. A failure gives cause 3. `boundLoad` copies both bounds into registers at the clock edge. After reset the window is 0 to all-ones.
- R6: The word comparison counts only when both runs passed their absolute tests. A mismatch then gives cause 4.
- R7: Within one run the causes rank parity over instruction over address. When either run fails an absolute test, the cause reported is that of the first run if the first run failed, and otherwise that of the second run.
- R8: `done` is high for exactly the one cycle after the cycle holding the second strobe. `pass` and `cause` change only in that cycle and keep their values until the next `done`.
- R9: Synchronous reset clears `done`, `pass` and `cause` and discards a stored first result, so the next strobe is treated as a first run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundLoad | input | 1 | Load the address window registers |
| boundLo | input | ADDR_W | Lowest legal address (inclusive) |
| boundHi | input | ADDR_W | Highest legal address (inclusive) |
| resultValid | input | 1 | Marks a result from one run |
| resultData | input | DATA_W | Result word |
| resultParity | input | 1 | Parity bit carried with the result |
| resultAddr | input | ADDR_W | Address the result belongs to |
| instrValid | input | 1 | Producing instruction was valid |
| done | output | 1 | One-cycle verdict pulse |
| pass | output | 1 | Verdict: both runs accepted and equal |
| cause | output | 3 | 0 pass, 1 parity, 2 instruction, 3 address, 4 mismatch |

## Verification
The bench builds the checker with a 16-bit result word, an 8-bit address and even parity. With these widths the window edges sit a few counts apart, so each bound and its neighbour outside the window can be hit directly. Parity faults are made by flipping the carried bit against a computed XOR. Runs arrive both back to back and with gaps, and a reset is applied while a first result is stored.

// File: rtl/duplex_chk_pkg.sv
package duplex_chk_pkg;

  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_PARITY   = 3'd1,
    CAUSE_INSTR    = 3'd2,
    CAUSE_RANGE    = 3'd3,
    CAUSE_MISMATCH = 3'd4
  } cause_e;

  typedef struct packed {
    logic captureFirst;
    logic finish;
  } ctrl_s;

endpackage

// File: rtl/duplex_chk_control.sv
module duplex_chk_control
  import duplex_chk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  resultValid,
  output ctrl_s ctrl,
  output logic  doneQ
);

  typedef enum logic {PH_FIRST, PH_SECOND} phase_e;

  phase_e phaseQ;
  phase_e phaseD;

  always_comb begin
    ctrl   = '0;
    phaseD = phaseQ;
    if (resultValid) begin
      if (phaseQ == PH_FIRST) begin
        ctrl.captureFirst = 1'b1;
        phaseD            = PH_SECOND;
      end else begin
        ctrl.finish = 1'b1;
        phaseD      = PH_FIRST;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= PH_FIRST;
      doneQ  <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      doneQ  <= ctrl.finish;
    end
  end

endmodule

// File: rtl/duplex_chk_datapath.sv
module duplex_chk_datapath
  import duplex_chk_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrl_s               ctrl,
  input  logic                boundLoad,
  input  logic [ADDR_W-1:0]   boundLo,
  input  logic [ADDR_W-1:0]   boundHi,
  input  logic [DATA_W-1:0]   resultData,
  input  logic                resultParity,
  input  logic [ADDR_W-1:0]   resultAddr,
  input  logic                instrValid,
  output logic                passQ,
  output logic [CAUSE_W-1:0]  causeQ
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] loQ, hiQ;
  logic [DATA_W-1:0] firstDataQ;
  cause_e            firstCauseQ;
  logic              parityOk, addrOk;
  cause_e            runCause, verdict;

  // Parity sense chosen by parameter
  generate
    if (ODD_PARITY) begin : g_oddPar
      assign parityOk = ((^resultData) ^ resultParity) == 1'b1;
    end else begin : g_evenPar
      assign parityOk = ((^resultData) ^ resultParity) == 1'b0;
    end
  endgenerate

  assign addrOk = (resultAddr >= loQ) && (resultAddr <= hiQ);

  // Absolute tests of the current run, ranked
  always_comb begin
    if (!parityOk)        runCause = CAUSE_PARITY;
    else if (!instrValid) runCause = CAUSE_INSTR;
    else if (!addrOk)     runCause = CAUSE_RANGE;
    else                  runCause = CAUSE_NONE;
  end

  // Final decision: earliest absolute failure first, relative test last
  always_comb begin
    if (firstCauseQ != CAUSE_NONE)       verdict = firstCauseQ;
    else if (runCause != CAUSE_NONE)     verdict = runCause;
    else if (firstDataQ != resultData)   verdict = CAUSE_MISMATCH;
    else                                 verdict = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loQ <= '0;
      hiQ <= ADDR_MAX;
    end else if (boundLoad) begin
      loQ <= boundLo;
      hiQ <= boundHi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      firstDataQ  <= '0;
      firstCauseQ <= CAUSE_NONE;
    end else if (ctrl.captureFirst) begin
      firstDataQ  <= resultData;
      firstCauseQ <= runCause;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      passQ  <= 1'b0;
      causeQ <= '0;
    end else if (ctrl.finish) begin
      passQ  <= (verdict == CAUSE_NONE);
      causeQ <= verdict;
    end
  end

endmodule

// File: rtl/duplex_result_checker.sv
module duplex_result_checker
  import duplex_chk_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               boundLoad,
  input  logic [ADDR_W-1:0]  boundLo,
  input  logic [ADDR_W-1:0]  boundHi,
  input  logic               resultValid,
  input  logic [DATA_W-1:0]  resultData,
  input  logic               resultParity,
  input  logic [ADDR_W-1:0]  resultAddr,
  input  logic               instrValid,
  output logic               done,
  output logic               pass,
  output logic [2:0]         cause
);

  ctrl_s ctrl;

  duplex_chk_control u_control (
    .clk         (clk),
    .rst         (rst),
    .resultValid (resultValid),
    .ctrl        (ctrl),
    .doneQ       (done)
  );

  duplex_chk_datapath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .ODD_PARITY (ODD_PARITY)
  ) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrl),
    .boundLoad    (boundLoad),
    .boundLo      (boundLo),
    .boundHi      (boundHi),
    .resultData   (resultData),
    .resultParity (resultParity),
    .resultAddr   (resultAddr),
    .instrValid   (instrValid),
    .passQ        (pass),
    .causeQ       (cause)
  );

endmodule

// File: rtl/duplex_result_checker_sva.sv
module duplex_result_checker_sva (
  input logic       clk,
  input logic       rst,
  input logic       resultValid,
  input logic       done,
  input logic       pass,
  input logic [2:0] cause
);

  assert_done_after_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(resultValid));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(cause) && $stable(pass)));

  assert_pass_means_zero_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass == (cause == 3'd0)));

  assert_cause_legal_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (cause <= 3'd4));

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !pass && cause == 3'd0));

endmodule

bind duplex_result_checker duplex_result_checker_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .resultValid (resultValid),
  .done        (done),
  .pass        (pass),
  .cause       (cause)
);

// File: tb/duplex_result_checker_bench.sv
`timescale 1ns/1ps
module duplex_result_checker_bench;

  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          boundLoad = 1'b0;
  logic [AW-1:0] boundLo = '0, boundHi = '0;
  logic          resultValid = 1'b0;
  logic [DW-1:0] resultData = '0;
  logic          resultParity = 1'b0;
  logic [AW-1:0] resultAddr = '0;
  logic          instrValid = 1'b0;
  logic          done, pass;
  logic [2:0]    cause;

  always #4 clk = ~clk;

  duplex_result_checker #(.DATA_W(DW), .ADDR_W(AW), .ODD_PARITY(1'b0)) u_duplex_result_checker (
    .clk(clk), .rst(rst), .boundLoad(boundLoad), .boundLo(boundLo), .boundHi(boundHi),
    .resultValid(resultValid), .resultData(resultData), .resultParity(resultParity),
    .resultAddr(resultAddr), .instrValid(instrValid),
    .done(done), .pass(pass), .cause(cause)
  );

  typedef struct {
    bit       ePass;
    bit [2:0] eCause;
    string    tag;
  } exp_t;

  exp_t     sbQ[$];
  int       nRun = 0, nFail = 0;
  bit       finished = 0;
  logic [AW-1:0] expLo = '0, expHi = '1;

  function automatic bit [2:0] runCause(bit [DW-1:0] d, bit badPar, bit iv, bit [AW-1:0] a);
    if (badPar)                 return 3'd1;
    if (!iv)                    return 3'd2;
    if (a < expLo || a > expHi) return 3'd3;
    return 3'd0;
  endfunction

  task automatic driveOne(bit [DW-1:0] d, bit badPar, bit iv, bit [AW-1:0] a);
    resultValid  = 1'b1;
    resultData   = d;
    resultParity = (^d) ^ badPar;
    instrValid   = iv;
    resultAddr   = a;
  endtask

  // Driver: computes the expectation and pushes it, then drives both runs
  task automatic sendPair(string tag,
                          bit [DW-1:0] d1, bit bp1, bit iv1, bit [AW-1:0] a1,
                          bit [DW-1:0] d2, bit bp2, bit iv2, bit [AW-1:0] a2,
                          int gap);
    exp_t e;
    bit [2:0] c1, c2;
    c1 = runCause(d1, bp1, iv1, a1);
    c2 = runCause(d2, bp2, iv2, a2);
    if (c1 != 0)      e.eCause = c1;
    else if (c2 != 0) e.eCause = c2;
    else if (d1 != d2) e.eCause = 3'd4;
    else              e.eCause = 3'd0;
    e.ePass = (e.eCause == 3'd0);
    e.tag   = tag;
    sbQ.push_back(e);
    @(negedge clk);
    driveOne(d1, bp1, iv1, a1);
    @(negedge clk);
    resultValid = 1'b0;
    for (int i = 0; i < gap; i++) @(negedge clk);
    driveOne(d2, bp2, iv2, a2);
    @(negedge clk);
    resultValid = 1'b0;
  endtask

  task automatic check(string tag, bit ok, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per done pulse
  always @(posedge clk) begin
    #2;
    if (!rst && !finished && done) begin
      if (sbQ.size() == 0) begin
        check("R8 unexpected done", 1'b0, 1, 0);
      end else begin
        exp_t e;
        e = sbQ.pop_front();
        check({e.tag, " cause"}, cause == e.eCause, cause, e.eCause);
        check({e.tag, " pass"}, pass == e.ePass, pass, e.ePass);
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 done after reset", done == 1'b0, done, 0);
    check("R9 pass after reset", pass == 1'b0, pass, 0);
    check("R9 cause after reset", cause == 3'd0, cause, 0);
    rst = 1'b0;
    @(negedge clk);

    // R5 program a window
    boundLoad = 1'b1; boundLo = 8'h10; boundHi = 8'h20;
    expLo = 8'h10; expHi = 8'h20;
    @(negedge clk);
    boundLoad = 1'b0;

    sendPair("R1 equal good",     16'h1234, 0, 1, 8'h15, 16'h1234, 0, 1, 8'h15, 2);
    sendPair("R6 mismatch",       16'h1234, 0, 1, 8'h15, 16'h1235, 0, 1, 8'h15, 1);
    sendPair("R3 parity run1",    16'h00F0, 1, 1, 8'h15, 16'h00F0, 0, 1, 8'h15, 0);
    sendPair("R3 parity run2",    16'hA5A5, 0, 1, 8'h15, 16'hA5A5, 1, 1, 8'h15, 3);
    sendPair("R4 instr run2",     16'h0001, 0, 1, 8'h15, 16'h0001, 0, 0, 8'h15, 0);
    sendPair("R5 below low",      16'h0002, 0, 1, 8'h0F, 16'h0002, 0, 1, 8'h15, 1);
    sendPair("R5 at both bounds", 16'h0003, 0, 1, 8'h10, 16'h0003, 0, 1, 8'h20, 0);
    sendPair("R5 above high",     16'h0004, 0, 1, 8'h18, 16'h0004, 0, 1, 8'h21, 2);
    sendPair("R7 earliest run",   16'h0005, 0, 1, 8'h30, 16'h0005, 1, 1, 8'h15, 0);
    sendPair("R7 rank in run",    16'h0006, 1, 0, 8'h40, 16'h0006, 0, 1, 8'h15, 1);
    sendPair("R7 instr over addr",16'h0007, 0, 0, 8'h40, 16'h0007, 0, 1, 8'h15, 1);
    sendPair("R6 absolute first", 16'h0008, 0, 1, 8'h15, 16'h0009, 0, 0, 8'h15, 0);
    // R2 back-to-back pairs, no idle cycles between strobes
    sendPair("R2 back to back a", 16'hBEEF, 0, 1, 8'h11, 16'hBEEF, 0, 1, 8'h12, 0);
    sendPair("R2 back to back b", 16'hCAFE, 0, 1, 8'h13, 16'hCAF0, 0, 1, 8'h14, 0);

    // R8 outputs hold after the pulse
    repeat (4) @(negedge clk);
    check("R8 cause held", cause == 3'd4, cause, 4);
    check("R8 done low idle", done == 1'b0, done, 0);

    // R9 reset drops a stored first result
    @(negedge clk);
    driveOne(16'h7777, 0, 1, 8'h15);
    @(negedge clk);
    resultValid = 1'b0;
    rst = 1'b1;
    expLo = '0; expHi = '1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R9 reset clears cause", cause == 3'd0, cause, 0);
    sendPair("R9 fresh pair",     16'h1111, 0, 1, 8'hF0, 16'h1111, 0, 1, 8'hF0, 1);
    sendPair("R5 reset window",   16'h2222, 0, 1, 8'h00, 16'h2222, 0, 1, 8'hFF, 0);

    repeat (5) @(negedge clk);
    check("R2 all verdicts seen", sbQ.size() == 0, sbQ.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule